// File: doc/BRIEF.md
# CAN Receive Message Queue

This block sits between a CAN protocol engine and the software that reads received messages. Every frame the engine finishes is first captured in a background holding register. The block then decides whether the frame is kept. A frame is kept only if it completed without error, its identifier was accepted by the filter, and it was not sent by this node. Frames this node sent itself are kept only when the node is in loopback mode. A kept frame moves into a small first-in first-out queue of foreground entries. Software reads the entry at the head of that queue.

Software sees the head entry together with a receive-full flag, which it can poll or turn into an interrupt. To release the head entry, software writes one to clear the flag, which pops exactly one entry. If a kept frame arrives while every queue entry is occupied, that newest frame is thrown away. A sticky overrun status is then raised and can request an error interrupt. Transmission is not affected by a full queue. The identifier match, error detection and transmit state all come from outside the block as inputs.

Top module: `can_rxq_top`

## Requirements
- R1: A frame whose completion strobe arrives with frm_ok=1, id_hit=1 and tx_active=0 appears at head_frame, and rx_full goes to 1 two clock edges after the strobe edge, provided the queue had room.
- R2: A frame completing with frm_ok=0 or id_hit=0 is never entered into the queue: rx_full and the queue contents are unchanged.
- R3: A frame completing while tx_active=1 and loopback=0 is not entered into the queue and raises no receive interrupt.
- R4: With loopback=1, a frame completing while tx_active=1 is entered like any other frame. A frame completing with tx_active=0, for example after lost arbitration, is entered normally.
- R5: The queue holds DEPTH (default 4) entries and delivers them in arrival order. rx_full is 1 exactly while at least one entry is held. Each rxf_clr pulse pops one entry, and an rxf_clr pulse on an empty queue has no effect.
- R6: A frame that qualifies for entry while all DEPTH entries are held, with no pop in the same cycle, is dropped. ovr_flag is set, and the held entries and their order are unchanged.
- R7: ovr_flag stays 1 until an ovr_clr pulse. If a new overrun and ovr_clr occur in the same cycle, the flag stays set.
- R8: rx_irq equals rx_full AND rx_ie. ovr_irq equals ovr_flag AND ovr_ie.
- R9: After reset, the queue is empty and rx_full, rx_irq, ovr_flag and ovr_irq are all 0.
- R10: When a frame qualifies in the same cycle as an rxf_clr pop on a full queue, the frame is entered and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_done | input | 1 | One-cycle strobe: a frame has finished on the bus |
| frm_in | input | FRAME_W (99) | Frame contents {id[28:0], ide, rtr, dlc[3:0], data[63:0]} |
| frm_ok | input | 1 | The frame finished without a transmission error |
| id_hit | input | 1 | The identifier was accepted by the external filter |
| tx_active | input | 1 | This node was transmitting the frame when it finished |
| loopback | input | 1 | Loopback mode: self-sent frames are received normally |
| rx_ie | input | 1 | Receive interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| rxf_clr | input | 1 | Write-one-to-clear pulse on the receive-full flag; pops the head entry |
| ovr_clr | input | 1 | Write-one-to-clear pulse on the overrun status |
| head_frame | output | FRAME_W (99) | Oldest held entry |
| rx_full | output | 1 | At least one entry is held |
| rx_irq | output | 1 | Receive interrupt request |
| ovr_flag | output | 1 | Sticky overrun status |
| ovr_irq | output | 1 | Overrun interrupt request |

## Verification
The assertions check several properties on every cycle. The fill level never exceeds DEPTH. A pop without a simultaneous entry lowers the level by one. A full queue with a qualifying frame and no pop raises the overrun status and keeps the level. The overrun status is sticky, and masked interrupts stay low. They also check that an erroneous frame, or a self-sent frame outside loopback, never makes an empty queue non-empty.

Other behaviour is shown only by the bench's scenarios. These cover arrival order across a full fill and drain, and the data at the head after an overrun drop. They also cover entry of loopback and lost-arbitration frames, and the same-cycle pop-and-enter case on a full queue.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;

    localparam int ID_W    = 29;
    localparam int DLC_W   = 4;
    localparam int BYTES   = 8;
    localparam int DATA_W  = BYTES * 8;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ide;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } rx_frame_t;

    localparam int FRAME_W = $bits(rx_frame_t);

    // A completed frame may enter the queue only when it is clean,
    // accepted, and either foreign or looped back on purpose.
    function automatic logic frame_keep(input logic ok, input logic hit,
                                        input logic tx, input logic lb);
        return ok && hit && (!tx || lb);
    endfunction

endpackage

// File: rtl/can_rxq_bg.sv
module can_rxq_bg
    import can_rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frm_done,
    input  rx_frame_t frm_in,
    input  logic      frm_ok,
    input  logic      id_hit,
    input  logic      tx_active,
    input  logic      loopback,
    output rx_frame_t bg_frame,
    output logic      pend
);

    // Background register captures every finished frame; a rejected one
    // simply gets overwritten by the next capture.
    always_ff @(posedge clk) begin
        if (rst) begin
            bg_frame <= '0;
            pend     <= 1'b0;
        end else begin
            if (frm_done)
                bg_frame <= frm_in;
            pend <= frm_done && frame_keep(frm_ok, id_hit, tx_active, loopback);
        end
    end

endmodule

// File: rtl/can_rxq_fifo.sv
module can_rxq_fifo
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  rx_frame_t                  push_frame,
    input  logic                       pop,
    output rx_frame_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rx_frame_t       slot [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[g] <= '0;
            else if (push && (wr_ptr == AW'(g)))
                slot[g] <= push_frame;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push)
                wr_ptr <= bump(wr_ptr);
            if (pop)
                rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    assign head = slot[rd_ptr];

endmodule

// File: rtl/can_rxq_flags.sv
module can_rxq_flags (
    input  logic clk,
    input  logic rst,
    input  logic ovr_set,
    input  logic ovr_clr,
    input  logic ovr_ie,
    input  logic rx_full,
    input  logic rx_ie,
    output logic ovr_flag,
    output logic ovr_irq,
    output logic rx_irq
);

    // Set has priority so that a fresh overrun is never lost to a clear.
    always_ff @(posedge clk) begin
        if (rst)
            ovr_flag <= 1'b0;
        else if (ovr_set)
            ovr_flag <= 1'b1;
        else if (ovr_clr)
            ovr_flag <= 1'b0;
    end

    assign ovr_irq = ovr_flag && ovr_ie;
    assign rx_irq  = rx_full && rx_ie;

endmodule

// File: rtl/can_rxq_top.sv
module can_rxq_top
    import can_rxq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frm_done,
    input  logic [FRAME_W-1:0] frm_in,
    input  logic               frm_ok,
    input  logic               id_hit,
    input  logic               tx_active,
    input  logic               loopback,
    input  logic               rx_ie,
    input  logic               ovr_ie,
    input  logic               rxf_clr,
    input  logic               ovr_clr,
    output logic [FRAME_W-1:0] head_frame,
    output logic               rx_full,
    output logic               rx_irq,
    output logic               ovr_flag,
    output logic               ovr_irq
);

    localparam int CW = $clog2(DEPTH + 1);

    rx_frame_t       bg_frame;
    rx_frame_t       head;
    logic            pend;
    logic [CW-1:0]   lvl;
    logic            full;
    logic            pop;
    logic            push;
    logic            ovr_set;

    can_rxq_bg u_bg (
        .clk       (clk),
        .rst       (rst),
        .frm_done  (frm_done),
        .frm_in    (rx_frame_t'(frm_in)),
        .frm_ok    (frm_ok),
        .id_hit    (id_hit),
        .tx_active (tx_active),
        .loopback  (loopback),
        .bg_frame  (bg_frame),
        .pend      (pend)
    );

    assign full    = (lvl == CW'(DEPTH));
    assign pop     = rxf_clr && (lvl != '0);
    assign push    = pend && (!full || pop);
    assign ovr_set = pend && full && !pop;

    can_rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_frame (bg_frame),
        .pop        (pop),
        .head       (head),
        .level      (lvl)
    );

    assign rx_full    = (lvl != '0);
    assign head_frame = head;

    can_rxq_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .ovr_set  (ovr_set),
        .ovr_clr  (ovr_clr),
        .ovr_ie   (ovr_ie),
        .rx_full  (rx_full),
        .rx_ie    (rx_ie),
        .ovr_flag (ovr_flag),
        .ovr_irq  (ovr_irq),
        .rx_irq   (rx_irq)
    );

endmodule

// File: rtl/can_rxq_chk.sv
module can_rxq_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       frm_done,
    input logic                       frm_ok,
    input logic                       tx_active,
    input logic                       loopback,
    input logic                       rxf_clr,
    input logic                       ovr_clr,
    input logic                       rx_ie,
    input logic                       ovr_ie,
    input logic                       rx_full,
    input logic                       rx_irq,
    input logic                       ovr_flag,
    input logic                       ovr_irq,
    input logic                       pend,
    input logic [$clog2(DEPTH+1)-1:0] lvl
);

    localparam int CW = $clog2(DEPTH + 1);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        lvl <= CW'(DEPTH)); // R5

    AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
        rx_full && rxf_clr && !pend |=> lvl == $past(lvl) - CW'(1)); // R5

    AST_BAD_FRAME_DROP: assert property (@(posedge clk) disable iff (rst)
        frm_done && !frm_ok && !rx_full && !pend |=> ##1 !rx_full); // R2

    AST_SELF_TX_DROP: assert property (@(posedge clk) disable iff (rst)
        frm_done && tx_active && !loopback && !rx_full && !pend
        |=> ##1 (!rx_full && !rx_irq)); // R3

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        pend && lvl == CW'(DEPTH) && !rxf_clr
        |=> ovr_flag && lvl == CW'(DEPTH)); // R6

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovr_flag && !ovr_clr |=> ovr_flag); // R7

    AST_RX_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        !rx_ie |-> !rx_irq); // R8

    AST_OVR_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        !ovr_ie |-> !ovr_irq); // R8

endmodule

bind can_rxq_top can_rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frm_done  (frm_done),
    .frm_ok    (frm_ok),
    .tx_active (tx_active),
    .loopback  (loopback),
    .rxf_clr   (rxf_clr),
    .ovr_clr   (ovr_clr),
    .rx_ie     (rx_ie),
    .ovr_ie    (ovr_ie),
    .rx_full   (rx_full),
    .rx_irq    (rx_irq),
    .ovr_flag  (ovr_flag),
    .ovr_irq   (ovr_irq),
    .pend      (pend),
    .lvl       (lvl)
);

// File: tb/sim_can_rxq_top.sv
module sim_can_rxq_top;
    import can_rxq_pkg::*;

    localparam int DEPTH = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               frm_done = 1'b0;
    logic [FRAME_W-1:0] frm_in = '0;
    logic               frm_ok = 1'b0;
    logic               id_hit = 1'b0;
    logic               tx_active = 1'b0;
    logic               loopback = 1'b0;
    logic               rx_ie = 1'b1;
    logic               ovr_ie = 1'b1;
    logic               rxf_clr = 1'b0;
    logic               ovr_clr = 1'b0;
    logic [FRAME_W-1:0] head_frame;
    logic               rx_full;
    logic               rx_irq;
    logic               ovr_flag;
    logic               ovr_irq;

    int checks = 0;
    int fails  = 0;
    logic [FRAME_W-1:0] exp_q[$];
    logic               ovr_m = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    can_rxq_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .frm_done(frm_done), .frm_in(frm_in),
        .frm_ok(frm_ok), .id_hit(id_hit), .tx_active(tx_active),
        .loopback(loopback), .rx_ie(rx_ie), .ovr_ie(ovr_ie),
        .rxf_clr(rxf_clr), .ovr_clr(ovr_clr), .head_frame(head_frame),
        .rx_full(rx_full), .rx_irq(rx_irq), .ovr_flag(ovr_flag),
        .ovr_irq(ovr_irq)
    );

    task automatic check(input string req, input logic [FRAME_W-1:0] act,
                         input logic [FRAME_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [FRAME_W-1:0] mk(input int n);
        rx_frame_t f;
        f.id   = ID_W'(32'h0ABC_0000 + n);
        f.ide  = n[0];
        f.rtr  = 1'b0;
        f.dlc  = DLC_W'(n % 9);
        f.data = {8{8'(n * 7 + 1)}};
        return f;
    endfunction

    // Driver: presents one finished frame and predicts the outcome.
    task automatic send(input logic [FRAME_W-1:0] f, input logic ok,
                        input logic hit, input logic tx, input logic lb);
        @(negedge clk);
        frm_in = f; frm_ok = ok; id_hit = hit; tx_active = tx; loopback = lb;
        frm_done = 1'b1;
        @(negedge clk);
        frm_done = 1'b0; frm_ok = 1'b0; id_hit = 1'b0; tx_active = 1'b0;
        @(negedge clk);
        if (ok && hit && (!tx || lb)) begin
            if (exp_q.size() < DEPTH) exp_q.push_back(f);
            else ovr_m = 1'b1;
        end
    endtask

    // Monitor: compares the head with the scoreboard front, then pops it.
    task automatic take(input string req);
        check(req, rx_full, 1'b1);
        if (exp_q.size() != 0) begin
            check(req, head_frame, exp_q[0]);
            void'(exp_q.pop_front());
        end
        rxf_clr = 1'b1;
        @(negedge clk);
        rxf_clr = 1'b0;
    endtask

    task automatic level_ok(input string req);
        check(req, rx_full, exp_q.size() != 0);
        check(req, ovr_flag, ovr_m);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 rx_full", rx_full, 1'b0);
        check("R9 rx_irq", rx_irq, 1'b0);
        check("R9 ovr_flag", ovr_flag, 1'b0);
        check("R9 ovr_irq", ovr_irq, 1'b0);

        // R1 basic entry and R8 receive interrupt
        send(mk(1), 1, 1, 0, 0);
        level_ok("R1 entry");
        check("R8 rx_irq on", rx_irq, 1'b1);
        rx_ie = 1'b0;
        @(negedge clk);
        check("R8 rx_irq masked", rx_irq, 1'b0);
        rx_ie = 1'b1;
        take("R1 head");
        level_ok("R5 empty after pop");

        // R5 clear on empty ignored
        rxf_clr = 1'b1; @(negedge clk); rxf_clr = 1'b0;
        level_ok("R5 clear on empty");

        // R2 error / mismatch frames dropped
        send(mk(2), 0, 1, 0, 0);
        level_ok("R2 error frame");
        send(mk(3), 1, 0, 0, 0);
        level_ok("R2 id mismatch");

        // R3 own frame outside loopback
        send(mk(4), 1, 1, 1, 0);
        level_ok("R3 self frame");
        check("R3 no rx_irq", rx_irq, 1'b0);

        // R4 loopback and lost arbitration
        send(mk(5), 1, 1, 1, 1);
        level_ok("R4 loopback");
        send(mk(6), 1, 1, 0, 0);
        take("R4 loopback head");
        take("R4 lost arbitration head");

        // R5 order over a full fill, R6 overrun drop
        for (int i = 10; i < 10 + DEPTH; i++) send(mk(i), 1, 1, 0, 0);
        level_ok("R5 full");
        check("R6 no overrun yet", ovr_flag, 1'b0);
        send(mk(20), 1, 1, 0, 0);
        level_ok("R6 overrun");
        check("R8 ovr_irq", ovr_irq, 1'b1);
        ovr_ie = 1'b0;
        @(negedge clk);
        check("R8 ovr_irq masked", ovr_irq, 1'b0);
        ovr_ie = 1'b1;
        for (int i = 0; i < DEPTH; i++) take("R6/R5 drain order");
        level_ok("R5 drained");

        // R7 sticky and clear
        check("R7 sticky", ovr_flag, 1'b1);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; ovr_m = 1'b0;
        @(negedge clk);
        level_ok("R7 cleared");

        // R10 pop and entry in the same cycle on a full queue
        for (int i = 30; i < 30 + DEPTH; i++) send(mk(i), 1, 1, 0, 0);
        @(negedge clk);
        frm_in = mk(40); frm_ok = 1'b1; id_hit = 1'b1; frm_done = 1'b1;
        @(negedge clk);
        frm_done = 1'b0; frm_ok = 1'b0; id_hit = 1'b0; rxf_clr = 1'b1;
        @(negedge clk);
        rxf_clr = 1'b0;
        void'(exp_q.pop_front());
        exp_q.push_back(mk(40));
        level_ok("R10 no overrun");
        for (int i = 0; i < DEPTH; i++) take("R10 order");
        level_ok("R10 drained");

        // R7 set wins over clear: overrun and clear together
        for (int i = 50; i < 50 + DEPTH; i++) send(mk(i), 1, 1, 0, 0);
        @(negedge clk);
        frm_in = mk(60); frm_ok = 1'b1; id_hit = 1'b1; frm_done = 1'b1;
        @(negedge clk);
        frm_done = 1'b0; frm_ok = 1'b0; id_hit = 1'b0; ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0; ovr_m = 1'b1;
        level_ok("R7 set beats clear");
        for (int i = 0; i < DEPTH; i++) take("R6 drain");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule